// File: doc/BRIEF.md
# CompactFlash PIO Cycle Timing Engine

This block runs single true-IDE register read and write cycles toward a CompactFlash card in programmed-I/O mode. A host raises a one-cycle start request carrying a 4-bit register address, a direction bit and write data. The engine then walks four phases in order: address setup, strobe, hold and recovery. It drives the card chip-selects, address lines, the read and write strobes and the data-out enable. When the whole cycle is over it returns a one-cycle done pulse and, for reads, the captured byte.

Phase lengths come from a per-mode nanosecond table for the seven PIO modes. The table is turned into clock counts at elaboration time from the `CLK_PS` clock-period parameter. The conversion rounds up, but forgives a small overshoot past a clock boundary. If the phases together are shorter than the mode's minimum cycle time, clocks are added one at a time to the non-zero phases in turn until the minimum is reached.

A mode-load strobe changes the active mode under a "never speed up" policy. A status read that returns the floating-bus pattern is cleaned up before it reaches the host.

Top module: `cf_pio_engine`

## Requirements
- R1: A phase of `ns` nanoseconds takes `clk = (ps + P - 1 - e) / P` clocks, where `ps = ns*1000` and `P = CLK_PS`. Here `e = min(ps*2/100, P/4)` when `ps > 0`, and a phase of 0 ns takes 0 clocks. The busy span of a cycle with no wait extension equals the larger of two values: the sum of the converted phases, or the converted minimum cycle time.
- R2: If the converted phases add up to less than the converted minimum cycle, one clock at a time goes to the next non-zero phase. The order is setup, strobe, hold, recovery, then back to setup, and it stops as soon as the minimum is met. Every cycle's phase lengths match this distribution.
- R3: Phases run in the order setup, strobe, hold, recovery. A chip-select is low during setup, strobe and hold, and both chip-selects are high during recovery. A recovery phase of 0 clocks is skipped.
- R4: A read pulses only `cf_iord_n_o` low and a write pulses only `cf_iowr_n_o` low, for the strobe phase. Both strobes are never low together. During a write, `cf_doe_o` is high from setup through hold and `cf_d_o` carries the write data.
- R5: Address bit 3 selects the chip-select: 0 drives `cf_cs_n_o = 2'b10` and 1 drives `cf_cs_n_o = 2'b01`. Bits 2:0 drive `cf_a_o`.
- R6: While `cf_wait_i` is high in the last strobe clock, the strobe is extended one clock at a time.
- R7: `done_o` pulses for exactly one clock after the last phase, and `busy_o` is then low. `rdata_o` is updated at that point for reads only and holds its value across writes.
- R8: A start request while `busy_o` is high is ignored: it neither changes the running cycle nor queues another one.
- R9: A read that returns 0xF9 is reported as 0x7F, but only from the status register (address 4'h7) or the alternate-status register (address 4'hE). Every other read value and address passes through unchanged.
- R10: A loaded mode above 6 is clamped to 6. The first load after reset is always taken. After that, a load is taken only if it is lower than the active mode. `mode_o` shows the active mode.
- R11: After reset the engine is idle. `busy_o`, `done_o` and `cf_doe_o` are low, both strobes and both chip-selects are high, and the active mode is 0 and counts as not yet set.

Phase lengths for a cycle are taken from the active mode at the clock where the start request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a cycle (taken when idle) |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Bit 3 selects chip-select, bits 2:0 the register |
| wdata_i | input | DATA_W | Write data |
| mode_i | input | 3 | Requested PIO mode |
| mode_load_i | input | 1 | Apply `mode_i` under the mode policy |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Last read result, after fix-up |
| mode_o | output | 3 | Active mode |
| cf_cs_n_o | output | 2 | Card chip-selects, active low |
| cf_a_o | output | 3 | Card register address |
| cf_iord_n_o | output | 1 | Read strobe, active low |
| cf_iowr_n_o | output | 1 | Write strobe, active low |
| cf_wait_i | input | 1 | Card wait, extends strobe while high |
| cf_d_o | output | DATA_W | Card write data |
| cf_doe_o | output | 1 | Card data drive enable |
| cf_d_i | input | DATA_W | Card read data |

## Verification
A wrong phase counter shows up within the same cycle: the bench counts every clock spent in setup, strobe, hold and recovery, so a length that is off by one appears at the done pulse. A bad padding distribution or a wrong mode entry shows up as mismatched phase lengths on the first cycle run in the affected mode. A mode register that breaks the slow-down-only policy changes `mode_o` on the clock after the offending load, and the phase lengths of the next cycle move with it. A lost capture or fix-up shows up on `rdata_o` at the next done pulse.

// File: rtl/cf_pio_pkg.sv
package cf_pio_pkg;

    localparam int NUM_MODES = 7;
    localparam int MAX_MODE  = NUM_MODES - 1;
    localparam int MODE_W    = 3;
    localparam int TW        = 16;
    localparam int HADDR_W   = 4;
    localparam int REG_W     = 3;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_SETUP = 3'd1,
        PH_STRB  = 3'd2,
        PH_HOLD  = 3'd3,
        PH_RECOV = 3'd4
    } phase_e;

    typedef struct packed {
        logic [TW-1:0] s;
        logic [TW-1:0] t;
        logic [TW-1:0] h;
        logic [TW-1:0] r;
    } clk_set_t;

    // nanosecond figures per PIO mode
    function automatic int ns_setup(input int m);
        case (m)
            0: return 70;  1: return 50;  2: return 30;  3: return 30;
            4: return 25;  5: return 15;  default: return 10;
        endcase
    endfunction

    function automatic int ns_strobe(input int m);
        case (m)
            0, 1, 2: return 290;
            3: return 80;  4: return 70;  5: return 65;  default: return 55;
        endcase
    endfunction

    function automatic int ns_addr_hold(input int m);
        case (m)
            0: return 20;  1: return 15;  default: return 10;
        endcase
    endfunction

    function automatic int ns_data_hold(input int m);
        case (m)
            0: return 30;  1: return 20;  2: return 15;  default: return 10;
        endcase
    endfunction

    function automatic int ns_recovery(input int m);
        case (m)
            0, 1, 2: return 0;
            3: return 70;  4: return 25;  5: return 25;  default: return 20;
        endcase
    endfunction

    function automatic int ns_min_cycle(input int m);
        case (m)
            0: return 600; 1: return 383; 2: return 240; 3: return 180;
            4: return 120; 5: return 100; default: return 80;
        endcase
    endfunction

    // ceiling division that forgives a small overshoot past a clock edge
    function automatic int ps_to_clk(input int ps, input int clk_ps);
        int slack;
        if (ps <= 0) return 0;
        slack = ps * 2 / 100;
        if (4 * slack > clk_ps) slack = clk_ps / 4;
        return (ps + clk_ps - 1 - slack) / clk_ps;
    endfunction

    // phase clocks with minimum-cycle padding spread round-robin
    function automatic clk_set_t build_set(input int m, input bit wr, input int clk_ps);
        int c0, c1, c2, c3, tot, mn, nz, per, rem;
        clk_set_t res;
        c0  = ps_to_clk(ns_setup(m) * 1000, clk_ps);
        c1  = ps_to_clk(ns_strobe(m) * 1000, clk_ps);
        c2  = ps_to_clk((wr ? ns_data_hold(m) : ns_addr_hold(m)) * 1000, clk_ps);
        c3  = ps_to_clk(ns_recovery(m) * 1000, clk_ps);
        tot = c0 + c1 + c2 + c3;
        mn  = ps_to_clk(ns_min_cycle(m) * 1000, clk_ps);
        nz  = (c0 != 0 ? 1 : 0) + (c1 != 0 ? 1 : 0) + (c2 != 0 ? 1 : 0) + (c3 != 0 ? 1 : 0);
        if (tot < mn && nz > 0) begin
            per = (mn - tot) / nz;
            rem = (mn - tot) % nz;
            if (c0 != 0) begin c0 = c0 + per + (rem > 0 ? 1 : 0); if (rem > 0) rem = rem - 1; end
            if (c1 != 0) begin c1 = c1 + per + (rem > 0 ? 1 : 0); if (rem > 0) rem = rem - 1; end
            if (c2 != 0) begin c2 = c2 + per + (rem > 0 ? 1 : 0); if (rem > 0) rem = rem - 1; end
            if (c3 != 0) begin c3 = c3 + per + (rem > 0 ? 1 : 0); end
        end
        res.s = TW'(c0);
        res.t = TW'(c1);
        res.h = TW'(c2);
        res.r = TW'(c3);
        return res;
    endfunction

endpackage

// File: rtl/cf_timing_table.sv
module cf_timing_table
    import cf_pio_pkg::*;
#(
    parameter int CLK_PS = 8000
) (
    input  logic [MODE_W-1:0] mode_i,
    input  logic              wr_i,
    output clk_set_t          set_o
);
    localparam int ENTRIES = 1 << MODE_W;

    clk_set_t rd_tab [ENTRIES];
    clk_set_t wr_tab [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_mode
        localparam int       M    = (g > MAX_MODE) ? MAX_MODE : g;
        localparam clk_set_t RD_V = build_set(M, 1'b0, CLK_PS);
        localparam clk_set_t WR_V = build_set(M, 1'b1, CLK_PS);
        assign rd_tab[g] = RD_V;
        assign wr_tab[g] = WR_V;
    end

    always_comb begin
        set_o = wr_i ? wr_tab[mode_i] : rd_tab[mode_i];
    end

endmodule

// File: rtl/cf_mode_ctrl.sv
module cf_mode_ctrl
    import cf_pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              load_i,
    output logic [MODE_W-1:0] mode_o
);
    localparam logic [MODE_W-1:0] TOP_MODE = MODE_W'(MAX_MODE);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              vld;
    } mode_t;

    mode_t mode_d, mode_q;
    logic [MODE_W-1:0] req_d;

    always_comb begin
        mode_d = mode_q;
        req_d  = (mode_i > TOP_MODE) ? TOP_MODE : mode_i;
        if (load_i && (!mode_q.vld || req_d < mode_q.mode)) begin
            mode_d.mode = req_d;
            mode_d.vld  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    assign mode_o = mode_q.mode;

    a_r10_never_faster: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.vld && $past(mode_q.vld)) |-> (mode_q.mode <= $past(mode_q.mode)));

    a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.mode <= TOP_MODE);

endmodule

// File: rtl/cf_pio_seq.sv
module cf_pio_seq
    import cf_pio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               wr_i,
    input  logic [HADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    input  clk_set_t           set_i,
    input  logic               wait_i,
    input  logic [DATA_W-1:0]  card_d_i,
    output logic               busy_o,
    output logic               done_o,
    output logic [DATA_W-1:0]  rdata_o,
    output logic [1:0]         cs_n_o,
    output logic [REG_W-1:0]   a_o,
    output logic               iord_n_o,
    output logic               iowr_n_o,
    output logic [DATA_W-1:0]  d_o,
    output logic               doe_o
);
    localparam logic [TW-1:0]      ONE      = TW'(1);
    localparam logic [DATA_W-1:0]  FLOAT_V  = DATA_W'(8'hF9);
    localparam logic [DATA_W-1:0]  CLEAN_V  = DATA_W'(8'h7F);
    localparam logic [HADDR_W-1:0] STAT_A   = HADDR_W'(4'h7);
    localparam logic [HADDR_W-1:0] ALTST_A  = HADDR_W'(4'hE);

    typedef struct packed {
        phase_e              ph;
        logic [TW-1:0]       cnt;
        logic [TW-1:0]       t;
        logic [TW-1:0]       h;
        logic [TW-1:0]       r;
        logic                wr;
        logic [HADDR_W-1:0]  addr;
        logic [DATA_W-1:0]   wdat;
        logic [DATA_W-1:0]   cap;
        logic [DATA_W-1:0]   rdat;
        logic                done;
    } seq_t;

    seq_t seq_d, seq_q;
    logic is_stat_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        is_stat_d  = (seq_q.addr == STAT_A) || (seq_q.addr == ALTST_A);
        unique case (seq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    seq_d.ph   = PH_SETUP;
                    seq_d.cnt  = set_i.s - ONE;
                    seq_d.t    = set_i.t;
                    seq_d.h    = set_i.h;
                    seq_d.r    = set_i.r;
                    seq_d.wr   = wr_i;
                    seq_d.addr = addr_i;
                    seq_d.wdat = wdata_i;
                end
            end
            PH_SETUP: begin
                if (seq_q.cnt != '0) seq_d.cnt = seq_q.cnt - ONE;
                else begin
                    seq_d.ph  = PH_STRB;
                    seq_d.cnt = seq_q.t - ONE;
                end
            end
            PH_STRB: begin
                if (seq_q.cnt != '0) seq_d.cnt = seq_q.cnt - ONE;
                else if (!wait_i) begin
                    seq_d.ph  = PH_HOLD;
                    seq_d.cnt = seq_q.h - ONE;
                    seq_d.cap = (is_stat_d && card_d_i == FLOAT_V) ? CLEAN_V : card_d_i;
                end
            end
            PH_HOLD: begin
                if (seq_q.cnt != '0) seq_d.cnt = seq_q.cnt - ONE;
                else if (seq_q.r != '0) begin
                    seq_d.ph  = PH_RECOV;
                    seq_d.cnt = seq_q.r - ONE;
                end else begin
                    seq_d.ph   = PH_IDLE;
                    seq_d.done = 1'b1;
                    if (!seq_q.wr) seq_d.rdat = seq_q.cap;
                end
            end
            PH_RECOV: begin
                if (seq_q.cnt != '0) seq_d.cnt = seq_q.cnt - ONE;
                else begin
                    seq_d.ph   = PH_IDLE;
                    seq_d.done = 1'b1;
                    if (!seq_q.wr) seq_d.rdat = seq_q.cap;
                end
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    logic cs_act;
    assign cs_act   = (seq_q.ph == PH_SETUP) || (seq_q.ph == PH_STRB) || (seq_q.ph == PH_HOLD);
    assign cs_n_o   = {~(cs_act & seq_q.addr[HADDR_W-1]), ~(cs_act & ~seq_q.addr[HADDR_W-1])};
    assign a_o      = seq_q.addr[REG_W-1:0];
    assign iord_n_o = !((seq_q.ph == PH_STRB) && !seq_q.wr);
    assign iowr_n_o = !((seq_q.ph == PH_STRB) && seq_q.wr);
    assign d_o      = seq_q.wdat;
    assign doe_o    = cs_act & seq_q.wr;
    assign busy_o   = (seq_q.ph != PH_IDLE);
    assign done_o   = seq_q.done;
    assign rdata_o  = seq_q.rdat;

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        iord_n_o || iowr_n_o);

    a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!iord_n_o || !iowr_n_o) |-> ($countones(~cs_n_o) == 1));

    a_r5_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o));

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.ph == PH_STRB && wait_i) |=> (seq_q.ph == PH_STRB));

    a_r8_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(seq_q.addr));

endmodule

// File: rtl/cf_pio_engine.sv
module cf_pio_engine
    import cf_pio_pkg::*;
#(
    parameter int CLK_PS = 8000,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                wr_i,
    input  logic [3:0]          addr_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic [2:0]          mode_i,
    input  logic                mode_load_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [DATA_W-1:0]   rdata_o,
    output logic [2:0]          mode_o,
    output logic [1:0]          cf_cs_n_o,
    output logic [2:0]          cf_a_o,
    output logic                cf_iord_n_o,
    output logic                cf_iowr_n_o,
    input  logic                cf_wait_i,
    output logic [DATA_W-1:0]   cf_d_o,
    output logic                cf_doe_o,
    input  logic [DATA_W-1:0]   cf_d_i
);
    clk_set_t set_w;

    cf_mode_ctrl u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode_i),
        .load_i (mode_load_i),
        .mode_o (mode_o)
    );

    cf_timing_table #(.CLK_PS(CLK_PS)) u_table (
        .mode_i (mode_o),
        .wr_i   (wr_i),
        .set_o  (set_w)
    );

    cf_pio_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .wr_i     (wr_i),
        .addr_i   (addr_i),
        .wdata_i  (wdata_i),
        .set_i    (set_w),
        .wait_i   (cf_wait_i),
        .card_d_i (cf_d_i),
        .busy_o   (busy_o),
        .done_o   (done_o),
        .rdata_o  (rdata_o),
        .cs_n_o   (cf_cs_n_o),
        .a_o      (cf_a_o),
        .iord_n_o (cf_iord_n_o),
        .iowr_n_o (cf_iowr_n_o),
        .d_o      (cf_d_o),
        .doe_o    (cf_doe_o)
    );

endmodule

// File: tb/cf_pio_engine_tb.sv
module cf_pio_engine_tb;

    localparam int CLK_PS = 8000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0, wr_i = 1'b0, mode_load_i = 1'b0, cf_wait_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic [7:0] wdata_i = '0, cf_d_i = '0;
    logic [2:0] mode_i = '0;
    logic       busy_o, done_o, cf_iord_n_o, cf_iowr_n_o, cf_doe_o;
    logic [7:0] rdata_o, cf_d_o;
    logic [2:0] mode_o, cf_a_o;
    logic [1:0] cf_cs_n_o;

    always #4 clk = ~clk;

    cf_pio_engine #(.CLK_PS(CLK_PS), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wr_i(wr_i), .addr_i(addr_i),
        .wdata_i(wdata_i), .mode_i(mode_i), .mode_load_i(mode_load_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .mode_o(mode_o),
        .cf_cs_n_o(cf_cs_n_o), .cf_a_o(cf_a_o), .cf_iord_n_o(cf_iord_n_o),
        .cf_iowr_n_o(cf_iowr_n_o), .cf_wait_i(cf_wait_i), .cf_d_o(cf_d_o),
        .cf_doe_o(cf_doe_o), .cf_d_i(cf_d_i)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cur_m  = 0;
    bit m_set  = 0;
    logic [7:0] last_rd = 8'h00;

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog R7 actual=%0d expected<=150000 cycles", cyc);
            summary();
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    function automatic int b_ns(input int kind, input int m);
        int t_set[7]  = '{70, 50, 30, 30, 25, 15, 10};
        int t_stb[7]  = '{290, 290, 290, 80, 70, 65, 55};
        int t_ah[7]   = '{20, 15, 10, 10, 10, 10, 10};
        int t_dh[7]   = '{30, 20, 15, 10, 10, 10, 10};
        int t_rec[7]  = '{0, 0, 0, 70, 25, 25, 20};
        int t_min[7]  = '{600, 383, 240, 180, 120, 100, 80};
        case (kind)
            0: return t_set[m];
            1: return t_stb[m];
            2: return t_ah[m];
            3: return t_dh[m];
            4: return t_rec[m];
            default: return t_min[m];
        endcase
    endfunction

    function automatic int b_clk(input int ns);
        int ps, e;
        ps = ns * 1000;
        if (ps <= 0) return 0;
        e = ps * 2 / 100;
        if (e > CLK_PS / 4) e = CLK_PS / 4;
        return (ps + CLK_PS - 1 - e) / CLK_PS;
    endfunction

    task automatic b_set(input int m, input bit wr, output int s, output int t,
                         output int h, output int r);
        int ph[4];
        int tot, mn, i;
        ph[0] = b_clk(b_ns(0, m));
        ph[1] = b_clk(b_ns(1, m));
        ph[2] = b_clk(b_ns(wr ? 3 : 2, m));
        ph[3] = b_clk(b_ns(4, m));
        tot = ph[0] + ph[1] + ph[2] + ph[3];
        mn  = b_clk(b_ns(5, m));
        i = 0;
        while (tot < mn) begin
            if (ph[i] != 0) begin ph[i]++; tot++; end
            i = (i + 1) % 4;
        end
        s = ph[0]; t = ph[1]; h = ph[2]; r = ph[3];
    endtask

    // ---------------- stimulus tasks ----------------
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 0; mode_load_i = 0; cf_wait_i = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_m = 0; m_set = 0; last_rd = 8'h00;
        chk(!busy_o && !done_o && !cf_doe_o, "R11", "idle flags", {busy_o, done_o, cf_doe_o}, 0);
        chk(cf_cs_n_o == 2'b11 && cf_iord_n_o && cf_iowr_n_o, "R11", "pins idle",
            {cf_cs_n_o, cf_iord_n_o, cf_iowr_n_o}, 4'hF);
        chk(mode_o == 3'd0, "R11", "mode after reset", mode_o, 0);
    endtask

    task automatic load_mode(input int m);
        int c;
        @(negedge clk);
        mode_i = m[2:0]; mode_load_i = 1'b1;
        @(negedge clk);
        mode_load_i = 1'b0;
        c = (m > 6) ? 6 : m;
        if (!m_set || c < cur_m) begin cur_m = c; m_set = 1; end
        chk(mode_o == cur_m[2:0], "R10", "mode policy", mode_o, cur_m);
    endtask

    task automatic run(input bit wr, input logic [3:0] a, input logic [7:0] wd,
                       input logic [7:0] card, input int ext, input bit poke);
        int s, t, h, r, es, et, eh, er, tot, k;
        bit seen, ok_dir, ok_cs, ok_dat;
        logic [7:0] exp_rd;
        b_set(cur_m, wr, s, t, h, r);
        es = 0; et = 0; eh = 0; er = 0; tot = 0;
        seen = 0; ok_dir = 1; ok_cs = 1; ok_dat = 1;
        @(negedge clk);
        start_i = 1'b1; wr_i = wr; addr_i = a; wdata_i = wd; cf_d_i = card;
        @(negedge clk);
        if (poke) begin addr_i = ~a; wr_i = ~wr; wdata_i = ~wd; end
        else start_i = 1'b0;
        for (k = 0; k < 3000; k++) begin
            if (k == 3) start_i = 1'b0;
            if (done_o || !busy_o) break;
            tot++;
            if (!cf_iord_n_o || !cf_iowr_n_o) begin
                et++; seen = 1;
                ok_dir &= wr ? (!cf_iowr_n_o && cf_iord_n_o) : (!cf_iord_n_o && cf_iowr_n_o);
                if (wr) ok_dat &= cf_doe_o && (cf_d_o == wd);
                ok_cs &= (cf_cs_n_o == (a[3] ? 2'b01 : 2'b10)) && (cf_a_o == a[2:0]);
                cf_wait_i = (et < t + ext);
            end else if (cf_cs_n_o != 2'b11) begin
                if (seen) eh++; else es++;
                ok_cs &= (cf_cs_n_o == (a[3] ? 2'b01 : 2'b10)) && (cf_a_o == a[2:0]);
                if (wr) ok_dat &= cf_doe_o && (cf_d_o == wd);
                cf_wait_i = 1'b0;
            end else begin
                er++;
                cf_wait_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0; cf_wait_i = 1'b0;
        chk(done_o, "R7", "done reached", done_o, 1);
        chk(tot == s + t + h + r + ext, "R1", "busy span", tot, s + t + h + r + ext);
        chk(es == s, "R2", "setup clocks", es, s);
        chk(et == t + ext, ext > 0 ? "R6" : "R2", "strobe clocks", et, t + ext);
        chk(eh == h, "R2", "hold clocks", eh, h);
        chk(er == r, "R3", "recovery clocks", er, r);
        chk(ok_dir, "R4", "strobe direction", ok_dir, 1);
        chk(ok_cs, "R5", "chip select and address", ok_cs, 1);
        if (wr) chk(ok_dat, "R4", "write data drive", ok_dat, 1);
        if (!wr) begin
            exp_rd = ((a == 4'h7 || a == 4'hE) && card == 8'hF9) ? 8'h7F : card;
            last_rd = exp_rd;
            chk(rdata_o == exp_rd, "R9", "read data", rdata_o, exp_rd);
        end else begin
            chk(rdata_o == last_rd, "R7", "rdata kept on write", rdata_o, last_rd);
        end
        @(negedge clk);
        chk(!done_o && !busy_o, poke ? "R8" : "R7", "idle after done", {done_o, busy_o}, 0);
    endtask

    initial begin
        void'($urandom(32'd4242));
        do_reset();

        // unset mode runs as mode 0
        run(1'b0, 4'h0, 8'h00, 8'h5A, 0, 1'b0);

        // mode policy sequence
        load_mode(3);
        load_mode(5);
        load_mode(1);
        load_mode(7);
        load_mode(0);
        do_reset();
        load_mode(7);                         // clamp to 6
        run(1'b0, 4'h7, 8'h00, 8'hF9, 0, 1'b0);

        // directed per-mode corners
        for (int m = 0; m < 7; m++) begin
            do_reset();
            load_mode(m);
            run(1'b0, 4'h7, 8'h00, 8'hF9, 0, 1'b0);   // status fix-up
            run(1'b0, 4'hE, 8'h00, 8'hF9, 0, 1'b0);   // alt status fix-up
            run(1'b0, 4'h0, 8'h00, 8'hF9, 0, 1'b0);   // data reg untouched
            run(1'b0, 4'h7, 8'h00, 8'h50, 0, 1'b0);   // ordinary status
            run(1'b1, 4'h9, 8'hC3, 8'h00, 0, 1'b1);   // write + ignored start
            run(1'b0, 4'h2, 8'h00, 8'h3C, 3, 1'b1);   // wait stretch + ignored start
        end

        // random mix
        for (int n = 0; n < 60; n++) begin
            if ($urandom % 5 == 0) do_reset();
            if ($urandom % 3 == 0) load_mode($urandom % 8);
            run(1'($urandom % 2), 4'($urandom), 8'($urandom),
                ($urandom % 4 == 0) ? 8'hF9 : 8'($urandom),
                ($urandom % 4 == 0) ? int'($urandom % 5) : 0,
                1'($urandom % 2));
        end

        summary();
    end

endmodule